// File: doc/BRIEF.md
# EEPROM write buffer and protection controller

This block sits between the serial front end of a 2 Kbyte serial EEPROM and its non-volatile array. The front end hands it a start address, then a stream of data bytes, then a STOP strobe. The block gathers the bytes in a 16-slot latch buffer. A byte that falls inside the write-protected region is dropped. When STOP arrives and at least one byte was kept, the block runs a self-timed program cycle. During that cycle it reports busy, writes the kept bytes to the array one per clock, and ignores the front end.

A mode pin picks the buffer geometry. In page mode, up to 16 bytes fill one 16-byte page, and the address wraps inside the page. In multibyte mode, up to 8 bytes land, and the 9th byte returns to the start address. A single byte write is the one-byte case of either geometry.

Protection covers the upper half of the array. A pin pair chooses one of the four upper 256-byte blocks. A configuration byte, supplied from the array's top location, gives the 16-byte boundary inside that block and a flag bit. On the build with a write-control input, that input must also be high, and multibyte mode is not available.

Top module: `ee_wbuf_ctrl`

## Requirements
- R1: Page mode (mode_in low at the address strobe, or always when HAS_WC=1). Byte n of a transaction goes to slot (addr_in[3:0] + n) mod 16 of the page addr_in[10:4]. A later byte in the same slot replaces an earlier one.
- R2: Multibyte mode (mode_in high at the address strobe, HAS_WC=0). Byte n goes to slot (addr_in[3:0] + (n mod 8)) mod 16, so the 9th byte lands back on the start address.
- R3: stop_in sampled while idle, with at least one byte kept, raises busy on the next cycle. Busy stays high for PROG_CYC cycles. It stays high for 2*PROG_CYC cycles when the transaction is in multibyte mode and kept bytes lie in both 8-byte halves of the page (address bit 3 both 0 and 1).
- R4: In busy cycle i (counting from 0, for i < 16), mem_we is high exactly when slot i holds a kept byte. mem_addr is then {page, i} and mem_wdata is the last byte latched in that slot. mem_we is never high outside busy.
- R5: A byte is dropped when all of these hold: its address is at least {1'b1, pb_in, pcfg_in[7:4], 4'h0}, pen_in is high, and pcfg_in[2] is high. When HAS_WC=1, wc_in must also be high. When HAS_WC=0, wc_in has no effect. A dropped byte still advances the slot pointer.
- R6: stop_in with no kept byte leaves busy low and writes nothing.
- R7: While busy, addr_vld, data_vld and stop_in have no effect. The buffer is empty when busy falls.
- R8: After reset, busy and mem_we are low and the buffer is empty.
- R9: Data bytes are taken only between an address strobe and the next STOP. On the same cycle, stop_in wins over addr_vld, and addr_vld wins over data_vld.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_vld | input | 1 | Start-address strobe; opens a transaction |
| addr_in | input | 11 | Start address of the transaction |
| data_vld | input | 1 | Data byte strobe |
| data_in | input | 8 | Data byte |
| stop_in | input | 1 | STOP strobe; closes the transaction |
| mode_in | input | 1 | 1 = multibyte (8-byte) geometry, 0 = page (16-byte) geometry |
| pb_in | input | 2 | Selects the upper block where protection starts |
| pen_in | input | 1 | Protect enable |
| wc_in | input | 1 | Write-control input (used only when HAS_WC=1) |
| pcfg_in | input | 8 | Protect configuration: [7:4] boundary, [2] flag |
| busy | output | 1 | High for the whole program cycle |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 11 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
Each strobe is taken at the clock edge where it is sampled. The edge that samples stop_in raises busy in the following cycle, and slot i of the buffer appears on the write port i cycles after that. Busy falls exactly PROG_CYC or 2*PROG_CYC cycles after it rises. The bench keeps a behavioural model that advances on the same edges, one model for each of two instances: one without the write-control input and one with it. It compares busy, mem_we and, when a write is due, mem_addr and mem_wdata on every falling edge, which is half a cycle after the registers settle. No expected value depends on a guessed latency.

// File: rtl/ee_wbuf_ctrl.sv
module ee_wbuf_ctrl #(
  parameter int PROG_CYC = 40,
  parameter bit HAS_WC = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        addr_vld,
  input  logic [10:0] addr_in,
  input  logic        data_vld,
  input  logic [7:0]  data_in,
  input  logic        stop_in,
  input  logic        mode_in,
  input  logic [1:0]  pb_in,
  input  logic        pen_in,
  input  logic        wc_in,
  input  logic [7:0]  pcfg_in,
  output logic        busy,
  output logic        mem_we,
  output logic [10:0] mem_addr,
  output logic [7:0]  mem_wdata
);
  localparam int AW = 11;
  localparam int SLOTS = 16;
  localparam int CW = $clog2(2 * PROG_CYC + 1);

  logic [CW-1:0]   rem;
  logic [4:0]      scan;
  logic            open_q, multi_q;
  logic [AW-1:0]   start_q;
  logic [3:0]      n_q;
  logic [SLOTS-1:0] mask_q;
  logic [7:0]      buf_q [SLOTS];

  wire [3:0]    idx     = start_q[3:0] + (multi_q ? {1'b0, n_q[2:0]} : n_q);
  wire [AW-1:0] a_cur   = {start_q[AW-1:4], idx};
  wire [AW-1:0] p_base  = {1'b1, pb_in, pcfg_in[7:4], 4'h0};
  wire          prot_on = pen_in & pcfg_in[2] & (HAS_WC ? wc_in : 1'b1);
  wire          hit     = prot_on & (a_cur >= p_base);
  wire          take    = !busy & open_q & data_vld & !stop_in & !addr_vld;
  wire          two_rows = multi_q & (|mask_q[7:0]) & (|mask_q[15:8]);
  wire [CW-1:0] dur     = two_rows ? CW'(2 * PROG_CYC) : CW'(PROG_CYC);

  assign busy      = rem != '0;
  assign mem_we    = busy & !scan[4] & mask_q[scan[3:0]];
  assign mem_addr  = {start_q[AW-1:4], scan[3:0]};
  assign mem_wdata = buf_q[scan[3:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem     <= '0;
      scan    <= '0;
      open_q  <= 1'b0;
      multi_q <= 1'b0;
      start_q <= '0;
      n_q     <= '0;
      mask_q  <= '0;
    end else if (busy) begin
      rem <= rem - CW'(1);
      if (!scan[4]) scan <= scan + 5'd1;
      if (rem == CW'(1)) mask_q <= '0;
    end else if (stop_in) begin
      open_q <= 1'b0;
      if (|mask_q) begin
        rem  <= dur;
        scan <= '0;
      end
    end else if (addr_vld) begin
      open_q  <= 1'b1;
      start_q <= addr_in;
      n_q     <= '0;
      mask_q  <= '0;
      multi_q <= HAS_WC ? 1'b0 : mode_in;
    end else if (take) begin
      n_q <= n_q + 4'd1;
      if (!hit) mask_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (take && !hit) buf_q[idx] <= data_in;
  end
endmodule

module ee_wbuf_chk #(
  parameter int PROG_CYC = 40
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mem_we,
  input logic        stop_in,
  input logic [10:0] mem_addr
);
  int run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 0;
    else if (busy) run <= run + 1;
    else run <= 0;
  end

  AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R4
  AST_WE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (run < 16)); // R4
  AST_ADDR_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && run != 0 && $past(mem_we)) |-> (mem_addr[3:0] > $past(mem_addr[3:0]))); // R4
  AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_in)); // R3
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run == PROG_CYC || run == 2 * PROG_CYC)); // R3
endmodule

bind ee_wbuf_ctrl ee_wbuf_chk #(.PROG_CYC(PROG_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_we(mem_we),
  .stop_in(stop_in), .mem_addr(mem_addr)
);

// File: tb/sim_ee_wbuf_ctrl.sv
module sim_ee_wbuf_ctrl;
  localparam int P = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_vld = 1'b0, data_vld = 1'b0, stop_in = 1'b0;
  logic [10:0] addr_in = '0;
  logic [7:0] data_in = '0;
  logic mode_in = 1'b0, pen_in = 1'b0, wc_in = 1'b0;
  logic [1:0] pb_in = '0;
  logic [7:0] pcfg_in = '0;
  logic busy0, we0, busy1, we1;
  logic [10:0] ma0, ma1;
  logic [7:0] md0, md1;

  always #10 clk = ~clk;

  ee_wbuf_ctrl #(.PROG_CYC(P), .HAS_WC(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_vld(addr_vld), .addr_in(addr_in),
    .data_vld(data_vld), .data_in(data_in), .stop_in(stop_in), .mode_in(mode_in),
    .pb_in(pb_in), .pen_in(pen_in), .wc_in(wc_in), .pcfg_in(pcfg_in),
    .busy(busy0), .mem_we(we0), .mem_addr(ma0), .mem_wdata(md0));

  ee_wbuf_ctrl #(.PROG_CYC(P), .HAS_WC(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .addr_vld(addr_vld), .addr_in(addr_in),
    .data_vld(data_vld), .data_in(data_in), .stop_in(stop_in), .mode_in(mode_in),
    .pb_in(pb_in), .pen_in(pen_in), .wc_in(wc_in), .pcfg_in(pcfg_in),
    .busy(busy1), .mem_we(we1), .mem_addr(ma1), .mem_wdata(md1));

  // behavioural reference, one per instance (v=0 no write control, v=1 with)
  int m_rem[2] = '{0, 0};
  int m_el[2] = '{0, 0};
  int m_open[2] = '{0, 0};
  int m_multi[2] = '{0, 0};
  int m_start[2] = '{0, 0};
  int m_n[2] = '{0, 0};
  int m_mask[2][16];
  int m_dat[2][16];

  int vectors = 0, fails = 0, cyc = 0;
  bit finished = 1'b0;
  string cur_req = "R8";

  initial begin
    for (int v = 0; v < 2; v++)
      for (int s = 0; s < 16; s++) begin m_mask[v][s] = 0; m_dat[v][s] = 0; end
  end

  always @(posedge clk) begin
    for (int v = 0; v < 2; v++) begin
      if (!rst_n) begin
        m_rem[v] = 0; m_el[v] = 0; m_open[v] = 0; m_n[v] = 0;
        for (int s = 0; s < 16; s++) m_mask[v][s] = 0;
      end else if (m_rem[v] > 0) begin
        m_el[v]++; m_rem[v]--;
        if (m_rem[v] == 0) for (int s = 0; s < 16; s++) m_mask[v][s] = 0;
      end else if (stop_in) begin
        int lo, hi;
        lo = 0; hi = 0;
        m_open[v] = 0;
        for (int s = 0; s < 8; s++) begin
          if (m_mask[v][s] != 0) lo = 1;
          if (m_mask[v][s+8] != 0) hi = 1;
        end
        if (lo + hi > 0) begin
          m_rem[v] = (m_multi[v] != 0 && lo != 0 && hi != 0) ? 2 * P : P;
          m_el[v] = 0;
        end
      end else if (addr_vld) begin
        m_open[v] = 1; m_start[v] = int'(addr_in); m_n[v] = 0;
        m_multi[v] = (v == 0) ? int'(mode_in) : 0;
        for (int s = 0; s < 16; s++) m_mask[v][s] = 0;
      end else if (data_vld && m_open[v] != 0) begin
        int idx, a, pbase;
        bit prot;
        idx = (m_multi[v] != 0) ? ((m_start[v] % 16) + (m_n[v] % 8)) % 16
                                : ((m_start[v] % 16) + m_n[v]) % 16;
        a = (m_start[v] / 16) * 16 + idx;
        pbase = 1024 + int'(pb_in) * 256 + int'(pcfg_in[7:4]) * 16;
        prot = pen_in && pcfg_in[2] && (v == 0 || wc_in) && (a >= pbase);
        if (!prot) begin m_mask[v][idx] = 1; m_dat[v][idx] = int'(data_in); end
        m_n[v] = (m_n[v] + 1) % 16;
      end
    end
  end

  task automatic cmp(int v, logic b, logic w, logic [10:0] a, logic [7:0] d);
    bit eb, ew;
    int ea;
    eb = m_rem[v] > 0;
    ew = eb && m_el[v] < 16 && m_mask[v][m_el[v] % 16] != 0;
    vectors++;
    if (b !== eb) begin
      fails++; $display("FAIL %s u%0d busy got %0b exp %0b", cur_req, v, b, eb);
    end
    if (w !== ew) begin
      fails++; $display("FAIL %s u%0d mem_we got %0b exp %0b", cur_req, v, w, ew);
    end else if (ew) begin
      ea = (m_start[v] / 16) * 16 + m_el[v];
      if (int'(a) != ea || int'(d) != m_dat[v][m_el[v]]) begin
        fails++;
        $display("FAIL %s u%0d write got %h/%h exp %h/%h", cur_req, v, a, d, ea[10:0],
                 m_dat[v][m_el[v]][7:0]);
      end
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      cmp(0, busy0, we0, ma0, md0);
      cmp(1, busy1, we1, ma1, md1);
      cyc++;
      if (cyc > 150000) begin
        fails++; finished = 1'b1;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
      end
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (m_rem[0] > 0 || m_rem[1] > 0) @(negedge clk);
  endtask

  task automatic send_addr(int a);
    @(negedge clk); addr_vld = 1'b1; addr_in = a[10:0];
    @(negedge clk); addr_vld = 1'b0;
  endtask

  task automatic send_data(int nb, int seed);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk); data_vld = 1'b1; data_in = 8'((seed + i * 37) & 255);
    end
    @(negedge clk); data_vld = 1'b0;
  endtask

  task automatic send_stop();
    @(negedge clk); stop_in = 1'b1;
    @(negedge clk); stop_in = 1'b0;
  endtask

  task automatic xfer(int a, int nb, int seed);
    wait_idle();
    send_addr(a);
    send_data(nb, seed);
    send_stop();
    repeat (2) @(negedge clk);
    wait_idle();
  endtask

  initial begin
    cur_req = "R8";
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cur_req = "R6"; send_stop(); repeat (4) @(negedge clk);      // R6 R8 empty after reset

    cur_req = "R1"; mode_in = 1'b0;
    xfer(11'h123, 3, 5);                                            // R1 short page write
    xfer(11'h05C, 20, 9);                                           // R1 wrap and overwrite
    cur_req = "R4"; xfer(11'h2F0, 1, 200);                         // R4 single byte at slot 0
    xfer(11'h2FF, 1, 77);                                           // R4 single byte at slot 15

    cur_req = "R2"; mode_in = 1'b1;
    xfer(11'h0A0, 10, 3);                                           // R2 9th byte back to start
    cur_req = "R3"; xfer(11'h0A6, 4, 50);                          // R3 spans two rows: 2x time
    xfer(11'h0AC, 8, 90);                                           // R3 wrap in page, both halves
    mode_in = 1'b0;
    xfer(11'h0A6, 4, 50);                                           // R3 page mode: single time

    cur_req = "R5"; pen_in = 1'b1; pcfg_in = 8'h34; pb_in = 2'd2;  // boundary 0x630
    wc_in = 1'b0; xfer(11'h636, 5, 11);                            // R5 u0 drops, u1 keeps
    wc_in = 1'b1; xfer(11'h636, 5, 12);                            // R5 R6 both drop
    xfer(11'h620, 6, 13);                                           // R5 below boundary kept
    xfer(11'h7F8, 4, 14);                                           // R5 top of array dropped
    pcfg_in = 8'h30; xfer(11'h636, 3, 15);                          // R5 flag clear: kept
    pcfg_in = 8'h34; pen_in = 1'b0; xfer(11'h636, 3, 16);          // R5 enable low: kept
    pen_in = 1'b1; pb_in = 2'd3; xfer(11'h636, 3, 17);             // R5 higher block: kept

    cur_req = "R7"; pen_in = 1'b0;
    wait_idle(); send_addr(11'h310); send_data(2, 40); send_stop();
    send_addr(11'h350); send_data(3, 60); send_stop();             // R7 ignored while busy
    repeat (2) @(negedge clk); wait_idle();
    send_stop(); repeat (4) @(negedge clk);                         // R7 buffer empty after cycle

    cur_req = "R9";
    send_data(3, 70); send_stop(); repeat (4) @(negedge clk);      // R9 no open transaction
    @(negedge clk); addr_vld = 1'b1; addr_in = 11'h111; data_vld = 1'b1; data_in = 8'hEE;
    @(negedge clk); addr_vld = 1'b0; data_in = 8'h42;              // R9 addr beats data
    @(negedge clk); data_vld = 1'b0; stop_in = 1'b1; addr_vld = 1'b1; addr_in = 11'h222;
    @(negedge clk); stop_in = 1'b0; addr_vld = 1'b0;               // R9 stop beats addr
    repeat (2) @(negedge clk); wait_idle();
    send_data(2, 80); send_stop(); repeat (4) @(negedge clk);      // R9 still closed

    cur_req = "R8";
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    send_stop(); repeat (4) @(negedge clk);                         // R8 reset clears state

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule